// File: doc/BRIEF.md
# Dual-Ratio Alternating Clock Divider

This block turns a fast crystal clock into a slow core clock whose average frequency may fall between two integer divide ratios. It has two ratios, and each is held for its own programmed number of output periods. The divider runs a burst of periods at the first ratio, then a burst at the second, and then repeats. For example, ratios 733 and 732 with bursts of 8 and 11 periods give an average close to 32.768 kHz from a 24 MHz crystal. With alternation off, the block is a plain integer divider. A bypass setting passes the crystal clock straight through.

Two 32-bit control words configure the block. Each ratio and burst length is stored as its value minus one. Separate input-gate and output-gate bits start and stop the divider. A status output reports whether either gate bit is set. Ratio and mode changes wait for the current output period to finish, so a reprogram never cuts a period short.

Top module: `cdiv_dual_ratio`

## Requirements
- R1: Field layout. In `ctrl_word0`, bits 11:0 hold the first ratio, bits 23:12 hold the second ratio, bit 28 turns on alternation, bit 30 is the output gate and bit 31 is the input gate. In `ctrl_word1`, bits 11:0 hold the first burst length, bits 23:12 hold the second burst length and bit 24 selects bypass. Every ratio and burst field encodes its value minus one, so a field value of 4 means 5.
- R2: With alternation off, every output period lasts N1 crystal cycles. It is high for floor(N1/2) cycles and then low for the remaining cycles.
- R3: With alternation on, the output runs M1 periods of N1 cycles, then M2 periods of N2 cycles, and repeats this pattern for as long as it stays enabled. Each period uses the high/low split of R2.
- R4: On the first rising crystal edge where the divider is running, the output goes high and a period at the first ratio begins.
- R5: When bypass is set and both gate bits are set, `clk_div` equals `clk_xtal`.
- R6: Whenever the output gate (bit 30) or the input gate (bit 31) is clear, `clk_div` is held low.
- R7: Clearing the input gate returns the sequence to its start. When the gate is set again, the first period uses the first ratio.
- R8: `div_enabled` is high exactly when bit 30 or bit 31 of `ctrl_word0` is set.
- R9: A change to a ratio or to the alternation bit during a period leaves that period's length unchanged. The change applies from the next period onward.
- R10: A synchronous active-high `rst` drives `clk_div` low and restarts the sequence at the first ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word0 | input | 32 | Ratios, alternation enable and gate bits (see R1) |
| ctrl_word1 | input | 32 | Burst lengths and bypass select (see R1) |
| clk_div | output | 1 | Divided (or bypassed) clock output |
| div_enabled | output | 1 | High when either gate bit is set |

## Verification
Two functions can land in the same crystal cycle: the end of a period and a reprogram of the ratio or alternation bit. The bench provokes this overlap by changing the control word two samples into a running period, in a process forked beside the period measurement. It then judges the outcome in two parts. The period that was running must keep its old length and split. The periods after it must follow the new setting; for example, clearing alternation during a second-ratio burst must fall back to the first ratio.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    // control word bit positions that the divider decodes
    localparam int DUAL_BIT = 28;
    localparam int OEN_BIT  = 30;
    localparam int IEN_BIT  = 31;
    localparam int BYP_BIT  = 24;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } cdiv_phase_e;
endpackage

// File: rtl/cdiv_cfg_decode.sv
module cdiv_cfg_decode #(
    parameter int RATIO_W = 12,
    parameter int RPT_W   = 12
) (
    input  logic [31:0]        ctrl_word0,
    input  logic [31:0]        ctrl_word1,
    output logic [RATIO_W-1:0] n1_f,
    output logic [RATIO_W-1:0] n2_f,
    output logic [RPT_W-1:0]   m1_f,
    output logic [RPT_W-1:0]   m2_f,
    output logic               dual_en,
    output logic               bypass_en,
    output logic               in_gate,
    output logic               out_gate
);
    import cdiv_pkg::*;

    // the second field sits directly above the first
    localparam int N2_LSB = RATIO_W;
    localparam int M2_LSB = RPT_W;

    always_comb begin
        n1_f      = ctrl_word0[0 +: RATIO_W];
        n2_f      = ctrl_word0[N2_LSB +: RATIO_W];
        m1_f      = ctrl_word1[0 +: RPT_W];
        m2_f      = ctrl_word1[M2_LSB +: RPT_W];
        dual_en   = ctrl_word0[DUAL_BIT];
        bypass_en = ctrl_word1[BYP_BIT];
        in_gate   = ctrl_word0[IEN_BIT];
        out_gate  = ctrl_word0[OEN_BIT];
    end
endmodule

// File: rtl/cdiv_phase_seq.sv
module cdiv_phase_seq #(
    parameter int RATIO_W = 12,
    parameter int RPT_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               boundary,
    input  logic               first,
    input  logic               dual_en,
    input  logic [RATIO_W-1:0] n1_f,
    input  logic [RATIO_W-1:0] n2_f,
    input  logic [RPT_W-1:0]   m1_f,
    input  logic [RPT_W-1:0]   m2_f,
    output logic [RATIO_W-1:0] nxt_ratio
);
    import cdiv_pkg::*;

    typedef struct packed {
        cdiv_phase_e       phase;
        logic [RPT_W-1:0]  rep;
    } seq_t;

    seq_t seq_q, seq_d;
    logic [RPT_W-1:0] burst_last;

    always_comb begin
        seq_d      = seq_q;
        burst_last = (seq_q.phase == PH_FIRST) ? m1_f : m2_f;
        if (!run) begin
            seq_d.phase = PH_FIRST;
            seq_d.rep   = '0;
        end else if (boundary) begin
            if (first || !dual_en) begin
                seq_d.phase = PH_FIRST;
                seq_d.rep   = '0;
            end else if (seq_q.rep == burst_last) begin
                seq_d.phase = (seq_q.phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
                seq_d.rep   = '0;
            end else begin
                seq_d.rep = seq_q.rep + 1'b1;
            end
        end
        nxt_ratio = (seq_d.phase == PH_SECOND) ? n2_f : n1_f;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.phase <= PH_FIRST;
            seq_q.rep   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R2: without alternation every new period is a first-ratio period
    p_single_first_r2: assert property (@(posedge clk) disable iff (rst)
        (run && boundary && !dual_en) |=> (seq_q.phase == PH_FIRST));

    // R7: a stopped divider waits at the start of the sequence
    p_idle_restart_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (seq_q.phase == PH_FIRST && seq_q.rep == '0));
endmodule

// File: rtl/cdiv_period_gen.sv
module cdiv_period_gen #(
    parameter int RATIO_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] nxt_ratio,
    output logic               boundary,
    output logic               first,
    output logic               out_q
);
    localparam int HW = RATIO_W + 1;

    typedef struct packed {
        logic               started;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               out;
    } per_t;

    per_t st_q, st_d;
    logic [HW-1:0] half_cur;
    logic [RATIO_W-1:0] cnt_inc;

    always_comb begin
        first    = run && !st_q.started;
        boundary = run && (!st_q.started || st_q.cnt == st_q.ratio);
        half_cur = ({1'b0, st_q.ratio} + HW'(1)) >> 1;
        cnt_inc  = st_q.cnt + 1'b1;
        st_d     = st_q;
        if (!run) begin
            st_d = '0;
        end else if (boundary) begin
            st_d.started = 1'b1;
            st_d.cnt     = '0;
            st_d.ratio   = nxt_ratio;
            st_d.out     = (nxt_ratio != '0);
        end else begin
            st_d.cnt = cnt_inc;
            st_d.out = ({1'b0, cnt_inc} < half_cur);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_q = st_q.out;

    // R2: the cycle counter never passes the period length
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.started |-> (st_q.cnt <= st_q.ratio));

    // R9: the ratio in use stays fixed inside a period
    p_ratio_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !boundary) |=> $stable(st_q.ratio));

    // R4: each period whose ratio is at least two opens with a high phase
    p_rise_at_start_r4: assert property (@(posedge clk) disable iff (rst)
        (boundary && nxt_ratio != '0) |=> st_q.out);
endmodule

// File: rtl/cdiv_dual_ratio.sv
module cdiv_dual_ratio #(
    parameter int RATIO_W = 12,
    parameter int RPT_W   = 12
) (
    input  logic        clk_xtal,
    input  logic        rst,
    input  logic [31:0] ctrl_word0,
    input  logic [31:0] ctrl_word1,
    output logic        clk_div,
    output logic        div_enabled
);
    logic [RATIO_W-1:0] n1_f, n2_f, nxt_ratio;
    logic [RPT_W-1:0]   m1_f, m2_f;
    logic dual_en, bypass_en, in_gate, out_gate;
    logic boundary, first, div_q, run;

    cdiv_cfg_decode #(.RATIO_W(RATIO_W), .RPT_W(RPT_W)) u_dec (
        .ctrl_word0 (ctrl_word0),
        .ctrl_word1 (ctrl_word1),
        .n1_f       (n1_f),
        .n2_f       (n2_f),
        .m1_f       (m1_f),
        .m2_f       (m2_f),
        .dual_en    (dual_en),
        .bypass_en  (bypass_en),
        .in_gate    (in_gate),
        .out_gate   (out_gate)
    );

    assign run = in_gate;

    cdiv_phase_seq #(.RATIO_W(RATIO_W), .RPT_W(RPT_W)) u_seq (
        .clk       (clk_xtal),
        .rst       (rst),
        .run       (run),
        .boundary  (boundary),
        .first     (first),
        .dual_en   (dual_en),
        .n1_f      (n1_f),
        .n2_f      (n2_f),
        .m1_f      (m1_f),
        .m2_f      (m2_f),
        .nxt_ratio (nxt_ratio)
    );

    cdiv_period_gen #(.RATIO_W(RATIO_W)) u_per (
        .clk       (clk_xtal),
        .rst       (rst),
        .run       (run),
        .nxt_ratio (nxt_ratio),
        .boundary  (boundary),
        .first     (first),
        .out_q     (div_q)
    );

    assign clk_div     = in_gate && out_gate && (bypass_en ? clk_xtal : div_q);
    assign div_enabled = in_gate || out_gate;

    // R6: a clear gate bit keeps the output low
    p_gated_low_r6: assert property (@(posedge clk_xtal) disable iff (rst)
        !(ctrl_word0[30] && ctrl_word0[31]) |-> !clk_div);
endmodule

// File: tb/tb_cdiv_dual_ratio.sv
module tb_cdiv_dual_ratio;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int NV = 5;
    localparam int V_N1[NV]   = '{5, 2, 3, 733, 7};
    localparam int V_N2[NV]   = '{9, 9, 4, 732, 2};
    localparam int V_M1[NV]   = '{1, 1, 2, 8,   1};
    localparam int V_M2[NV]   = '{1, 1, 3, 11,  1};
    localparam bit V_DUAL[NV] = '{0, 0, 1, 1,   1};
    localparam int V_PER[NV]  = '{3, 3, 10, 22, 6};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] ctrl_word0 = '0;
    logic [31:0] ctrl_word1 = '0;
    logic clk_div, div_enabled;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdiv_dual_ratio dut (
        .clk_xtal    (clk),
        .rst         (rst),
        .ctrl_word0  (ctrl_word0),
        .ctrl_word1  (ctrl_word1),
        .clk_div     (clk_div),
        .div_enabled (div_enabled)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1: field value is the ratio or count minus one
    function automatic logic [31:0] word0(int n1, int n2, bit dual, bit oen, bit ien);
        logic [31:0] w = '0;
        w[11:0]  = 12'(n1 - 1);
        w[23:12] = 12'(n2 - 1);
        w[28] = dual; w[30] = oen; w[31] = ien;
        return w;
    endfunction

    function automatic logic [31:0] word1(int m1, int m2, bit byp);
        logic [31:0] w = '0;
        w[11:0]  = 12'(m1 - 1);
        w[23:12] = 12'(m2 - 1);
        w[24] = byp;
        return w;
    endfunction

    task automatic wait_rise();
        do @(negedge clk); while (clk_div !== 1'b1);
    endtask

    // entered on the first high sample of a period; leaves on the next one
    task automatic measure_one(output int hi, output int tot);
        int lo;
        hi = 1; lo = 0;
        forever begin
            @(negedge clk);
            if (clk_div === 1'b1) hi++; else break;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (clk_div === 1'b0) lo++; else break;
        end
        tot = hi + lo;
    endtask

    task automatic expect_period(input string req, input int ratio);
        int hi, tot;
        measure_one(hi, tot);
        chk({req, " high"}, hi, ratio / 2);
        chk({req, " length"}, tot, ratio);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi, tot, lowcnt;
        // R10: reset holds output low even with the gates set
        ctrl_word0 = word0(4, 4, 0, 1, 1);
        ctrl_word1 = word1(1, 1, 0);
        repeat (3) @(negedge clk);
        chk("R10 reset low", int'(clk_div), 0);
        chk("R8 status in reset", int'(div_enabled), 1);

        // table walk: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rst = 1'b1;
            ctrl_word0 = word0(V_N1[v], V_N2[v], V_DUAL[v], 1, 1);
            ctrl_word1 = word1(V_M1[v], V_M2[v], 0);
            @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            chk("R4 high at first edge", int'(clk_div), 1);
            for (int p = 0; p < V_PER[v]; p++) begin
                int pos, r;
                pos = V_DUAL[v] ? (p % (V_M1[v] + V_M2[v])) : 0;
                r = (pos < V_M1[v]) ? V_N1[v] : V_N2[v];
                expect_period(V_DUAL[v] ? "R3 burst" : "R2 single", r);
            end
        end

        // R8: status for all gate combinations
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            ctrl_word0 = word0(4, 4, 0, g[0], g[1]);
            #1;
            chk("R8 status", int'(div_enabled), (g != 0) ? 1 : 0);
        end

        // R6: each gate alone leaves the output low
        for (int g = 1; g < 3; g++) begin
            ctrl_word0 = word0(4, 4, 0, g[0], g[1]);
            lowcnt = 0;
            repeat (20) begin
                @(negedge clk);
                if (clk_div !== 1'b0) lowcnt++;
            end
            chk("R6 gated high samples", lowcnt, 0);
        end

        // R7: dropping input gate restarts the sequence at the first ratio
        do_reset();
        ctrl_word0 = word0(3, 5, 1, 1, 1);
        ctrl_word1 = word1(1, 1, 0);
        wait_rise();
        expect_period("R7 pre N1", 3);
        ctrl_word0 = word0(3, 5, 1, 1, 0);
        repeat (3) @(negedge clk);
        chk("R7 stopped low", int'(clk_div), 0);
        ctrl_word0 = word0(3, 5, 1, 1, 1);
        @(negedge clk);
        chk("R7 restart high", int'(clk_div), 1);
        expect_period("R7 restart N1", 3);
        expect_period("R7 then N2", 5);

        // R9: ratio change mid period applies at the next boundary
        do_reset();
        ctrl_word0 = word0(6, 6, 0, 1, 1);
        ctrl_word1 = word1(1, 1, 0);
        wait_rise();
        fork
            measure_one(hi, tot);
            begin
                repeat (2) @(negedge clk);
                ctrl_word0 = word0(4, 6, 0, 1, 1);
            end
        join
        chk("R9 old length kept", tot, 6);
        chk("R9 old high kept", hi, 3);
        expect_period("R9 new ratio", 4);

        // R9: alternation cleared during a second-ratio burst
        do_reset();
        ctrl_word0 = word0(4, 6, 1, 1, 1);
        ctrl_word1 = word1(1, 5, 0);
        wait_rise();
        expect_period("R9 dual N1", 4);
        fork
            measure_one(hi, tot);
            begin
                repeat (2) @(negedge clk);
                ctrl_word0 = word0(4, 6, 0, 1, 1);
            end
        join
        chk("R9 N2 period kept", tot, 6);
        expect_period("R9 back to N1", 4);
        expect_period("R9 stays N1", 4);

        // R5: bypass passes the crystal clock
        @(negedge clk);
        ctrl_word1 = word1(1, 1, 1);
        repeat (4) begin
            @(posedge clk); #1;
            chk("R5 bypass high", int'(clk_div), 1);
            @(negedge clk); #1;
            chk("R5 bypass low", int'(clk_div), 0);
        end
        ctrl_word0 = word0(4, 6, 0, 0, 1);
        @(posedge clk); #1;
        chk("R6 bypass gated", int'(clk_div), 0);

        // R10: reset mid-run restarts at the first ratio
        @(negedge clk);
        ctrl_word1 = word1(1, 1, 0);
        ctrl_word0 = word0(5, 3, 1, 1, 1);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset mid-run low", int'(clk_div), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 restart high", int'(clk_div), 1);
        expect_period("R10 first N1", 5);
        expect_period("R10 then N2", 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule